// File: doc/BRIEF.md
# Push-Button Digit Stepper

This block lets a single push button set one hexadecimal display digit by stepping it upward. It runs on the fast system clock. A slow sample enable, pulsing at roughly 50 Hz (the 50 MHz clock divided by 2^20), decides when the raw button level is looked at. Sampling this slowly filters out contact bounce, so no separate debounce filter is needed.

Every enable pulse pushes the current button level into a two-deep sample history. The digit advances by one when the history holds a released sample followed by a pressed one. It wraps from 15 back to 0. A display driver uses four copies of the block, one per digit, and each copy has its own button. Handling metastability beyond the sample history is left to the surrounding logic.

Top module: `btn_digit_stepper`

## Requirements
- R1: While `rst_n` is low, `digit` is 0 and the sample history reads as released, so a press sampled right after reset is counted.
- R2: On each clock edge with `smp_en` high, `btn_raw` is shifted into the history. The previous newest sample becomes the older one.
- R3: On clock edges with `smp_en` low, neither the history nor `digit` changes, whatever `btn_raw` does.
- R4: `btn_raw` is active high (1 = pressed). On an enable pulse where the history shows older = released and newest = pressed, `digit` increases by one. A press first sampled at enable k therefore shows up in `digit` right after enable k+1.
- R5: Stepping is circular: the step after 15 (4'b1111) is 0.
- R6: A button held pressed across any number of enable pulses gives exactly one step.
- R7: Button bounce between enable pulses has no effect. Only the levels present on enable edges count.
- R8: Samples of pressed, released, pressed on successive enable pulses give two separate steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Slow sample enable, one clock wide, about 50 Hz |
| btn_raw | input | 1 | Raw button level, 1 = pressed |
| digit | output | 4 | Current digit value |

## Verification
Sampling a new button level and stepping the digit happen on the same enable edge. On that edge the step decision uses the history as it stood before the shift. The bench drives press, hold and release patterns on consecutive enables, including random bursts and presses exactly on the 15-to-0 wrap. After each enable it compares `digit` with a model that applies the step before the shift. Button toggling between enables is checked for having no effect on `digit`.

// File: rtl/btnctr_pkg.sv
package btnctr_pkg;
  localparam int unsigned HIST_W = 2;
  typedef logic [HIST_W-1:0] hist_t;
  // Oldest sample in the MSB, newest in the LSB.
  localparam hist_t RISE_PAT = 2'b01;
endpackage

// File: rtl/btnctr_sampler.sv
module btnctr_sampler
  import btnctr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic btn_raw,
  output logic rise
);
  hist_t hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    if (smp_en) hist_d = {hist_q[0], btn_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign rise = smp_en && (hist_q == RISE_PAT);

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> (hist_q[1] == $past(hist_q[0]))); // R2
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(hist_q)); // R3
endmodule

// File: rtl/btnctr_wrapcnt.sv
module btnctr_wrapcnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5
endmodule

// File: rtl/btn_digit_stepper.sv
module btn_digit_stepper #(
  parameter int unsigned DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en,
  input  logic               btn_raw,
  output logic [DIGIT_W-1:0] digit
);
  logic rise;

  btnctr_sampler u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_en  (smp_en),
    .btn_raw (btn_raw),
    .rise    (rise)
  );

  btnctr_wrapcnt #(.CNT_W(DIGIT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (rise),
    .cnt   (digit)
  );

  AST_NO_STEP_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(digit)); // R3
  AST_NO_STEP_WITHOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(digit)); // R6
endmodule

// File: tb/btn_digit_stepper_bench.sv
module btn_digit_stepper_bench;
  logic clk = 1'b0;
  logic rst_n, smp_en, btn_raw;
  logic [3:0] digit;
  int checks = 0, errors = 0;
  logic [1:0] m_hist;
  logic [3:0] m_cnt;
  bit done = 0;

  always #10 clk = ~clk;

  btn_digit_stepper u_btn_digit_stepper (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .btn_raw(btn_raw), .digit(digit)
  );

  function automatic logic [3:0] next_cnt(logic [1:0] h, logic [3:0] c);
    return (h == 2'b01) ? c + 4'd1 : c;
  endfunction

  task automatic check(string req, logic [3:0] exp);
    checks++;
    if (digit !== exp) begin
      errors++;
      $display("FAIL %s digit=%0d expected=%0d", req, digit, exp);
    end
  endtask

  // One enable pulse with level b; inputs change at negedge, sampled at next negedge.
  task automatic pulse(logic b, string req);
    btn_raw = b; smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
    m_cnt  = next_cnt(m_hist, m_cnt);
    m_hist = {m_hist[0], b};
    check(req, m_cnt);
  endtask

  // Idle cycles with button bouncing randomly.
  task automatic bounce(int n, string req);
    for (int i = 0; i < n; i++) begin
      btn_raw = 1'($urandom);
      @(negedge clk);
    end
    check(req, m_cnt);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; smp_en = 1'b0; btn_raw = 1'b1;
    m_hist = 2'b00; m_cnt = 4'd0;
    repeat (3) @(negedge clk);
    check("R1", 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: press right after reset is counted (history reads released)
    pulse(1'b1, "R1");
    pulse(1'b1, "R4");
    check("R4", 4'd1);
    // R6: hold
    for (int i = 0; i < 6; i++) pulse(1'b1, "R6");
    check("R6", 4'd1);
    // R3/R7: bouncing without enables
    bounce(40, "R7");
    bounce(5, "R3");
    // R8: press, release, press
    pulse(1'b0, "R8"); pulse(1'b1, "R8"); pulse(1'b0, "R8"); pulse(1'b1, "R8");
    pulse(1'b0, "R8");
    check("R8", 4'd3);
    // R2: shift order, 1 then 0 gives no step on next enable
    pulse(1'b1, "R2"); pulse(1'b1, "R2"); pulse(1'b0, "R2");
    // R5: wrap, step to 15 and beyond
    while (m_cnt != 4'd15) begin
      pulse(1'b1, "R5"); pulse(1'b0, "R5");
    end
    check("R5", 4'd15);
    pulse(1'b1, "R5"); pulse(1'b0, "R5");
    check("R5", 4'd0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      pulse(1'($urandom), "R4");
      if (($urandom % 4) == 0) bounce(1 + int'($urandom % 8), "R7");
    end
    // reset mid-run
    rst_n = 1'b0; m_hist = 2'b00; m_cnt = 4'd0;
    @(negedge clk);
    check("R1", 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog digit=%0d expected=finish", digit);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule